// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block sits between a processor's sequencer and the request lines of a fixed set of peripheral sources and internal trap conditions. Every cycle that it is free it looks at all raised lines and at the current 3-bit processor priority. It picks one winner and presents it to the sequencer as a take strobe together with a 9-bit vector address. The vector is hard-wired per source or per trap cause.

Trap conditions behave as if they sit one level above the top priority. They are never masked and always beat device requests. A device request is held off for as long as the processor priority is at or above the device's level, and a device may only be wired at levels 4 to 7.

Once a winner is presented, the strobe and vector stay frozen until the sequencer acknowledges. After the acknowledge the block raises a one-cycle clear pulse on the line of the accepted device, so that the device can drop its request. It then spends that cycle without arbitrating before it looks at the lines again.

Top module: `vec_irq_arbiter`

## Requirements
- R1: While reset is low, and in the first cycle after it, `take` is 0, `vector` is 0 and `dev_clr` is all zero.
- R2: A device request is not presented while `cpu_pri` is greater than or equal to that device's level. It is presented while `cpu_pri` is below that level.
- R3: Among several unmasked device requests the one with the highest level wins. A tie between equal levels goes to the lowest device index.
- R4: A raised trap line is presented whatever `cpu_pri` is, and it wins over every device request.
- R5: Among several raised trap lines the lowest trap index wins. Index 0 is bus timeout, and the remaining causes follow in ascending vector order.
- R6: The vectors (octal) are as follows. Devices 0..7: 060, 064, 070, 074 and 200 at level 4; 100 and 104 at level 6; 220 at level 5. Device levels by index are 4,4,4,4,6,6,4,5. Traps 0..10: 004, 010, 014, 020, 024, 030, 034, 114, 240, 244, 250.
- R7: While `take` is 1 and `ack` is 0, `take` stays 1 and `vector` does not change, whatever the request lines and `cpu_pri` do. `ack` has no effect while `take` is 0.
- R8: When `ack` is 1 while `take` is 1, the next cycle shows `take` 0. In that cycle `dev_clr` is one-hot on the accepted device index, or all zero if a trap was accepted, and it lasts exactly one cycle. No new winner is presented in that cycle.
- R9: When the block is free, a request that wins at a clock edge is visible on `take` and `vector` right after that edge. `vector` reads 0 whenever `take` is 0.
- R10: Every device level lies in 4..7, so with `cpu_pri` at 3 or lower any single device request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | 8 | Device request lines, one per source |
| trap_req | input | 11 | Trap condition lines, one per cause |
| cpu_pri | input | 3 | Current processor priority, 0..7 |
| ack | input | 1 | Sequencer acknowledge of the presented request |
| take | output | 1 | A request is being presented |
| vector | output | 9 | Vector address of the presented request |
| dev_clr | output | 8 | One-cycle clear pulse to the accepted device |

## Verification
A winner that is present at a clock edge while the block is free appears on `take` and `vector` right after that edge. An acknowledge seen at an edge drops `take` and raises `dev_clr` right after that edge. The earliest next winner follows one edge later, after the clear cycle. The bench drives inputs on the falling edge and steps a cycle-level reference model on the rising edge. It compares all outputs one time unit after each rising edge, so every result is checked in exactly the cycle it is due. Directed sequences cover masking at the boundary level, ties, trap-over-device and hold-until-acknowledge. Seeded random traffic then exercises mixed requests, priorities and acknowledges.

// File: rtl/virq_pkg.sv
package virq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_CLEAR = 2'd2
    } arb_state_e;

    localparam int unsigned MIN_DEV_LEVEL = 4;

endpackage

// File: rtl/virq_dev_select.sv
module virq_dev_select #(
    parameter int unsigned N_DEV = 8,
    parameter int unsigned LVL_W = 3,
    parameter int unsigned VEC_W = 9,
    parameter int unsigned SRC_W = 4,
    parameter logic [N_DEV*LVL_W-1:0] DEV_LVL = '0,
    parameter logic [N_DEV*VEC_W-1:0] DEV_VEC = '0
) (
    input  logic [N_DEV-1:0] req,
    input  logic [LVL_W-1:0] cpu_pri,
    output logic             found,
    output logic [SRC_W-1:0] idx,
    output logic [VEC_W-1:0] vec
);
    logic [N_DEV-1:0] eligible;

    // Per-source masking against the processor priority
    for (genvar g = 0; g < N_DEV; g++) begin : g_mask
        assign eligible[g] = req[g] && (DEV_LVL[g*LVL_W +: LVL_W] > cpu_pri);
    end

    logic [LVL_W-1:0] best_lvl;

    // Strictly-greater compare keeps the lowest index on ties
    always_comb begin
        found    = 1'b0;
        idx      = '0;
        vec      = '0;
        best_lvl = '0;
        for (int i = 0; i < N_DEV; i++) begin
            if (eligible[i] && (!found || DEV_LVL[i*LVL_W +: LVL_W] > best_lvl)) begin
                found    = 1'b1;
                idx      = SRC_W'(i);
                vec      = DEV_VEC[i*VEC_W +: VEC_W];
                best_lvl = DEV_LVL[i*LVL_W +: LVL_W];
            end
        end
    end

    // Levels 1..3 are never wired to a device
    initial begin
        for (int i = 0; i < N_DEV; i++) begin
            AST_DEV_LEVEL_LEGAL: assert (DEV_LVL[i*LVL_W +: LVL_W] >= LVL_W'(virq_pkg::MIN_DEV_LEVEL)); // R10
        end
    end

endmodule

// File: rtl/virq_trap_select.sv
module virq_trap_select #(
    parameter int unsigned N_TRAP = 11,
    parameter int unsigned VEC_W  = 9,
    parameter int unsigned SRC_W  = 4,
    parameter logic [N_TRAP*VEC_W-1:0] TRAP_VEC = '0
) (
    input  logic [N_TRAP-1:0] req,
    output logic              found,
    output logic [SRC_W-1:0]  idx,
    output logic [VEC_W-1:0]  vec
);
    // Fixed order: lowest index first
    always_comb begin
        found = 1'b0;
        idx   = '0;
        vec   = '0;
        for (int i = N_TRAP - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = SRC_W'(i);
                vec   = TRAP_VEC[i*VEC_W +: VEC_W];
            end
        end
    end

endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter #(
    parameter int unsigned N_DEV  = 8,
    parameter int unsigned N_TRAP = 11,
    parameter int unsigned LVL_W  = 3,
    parameter int unsigned VEC_W  = 9,
    parameter logic [N_DEV*LVL_W-1:0] DEV_LVL =
        {3'd5, 3'd4, 3'd6, 3'd6, 3'd4, 3'd4, 3'd4, 3'd4},
    parameter logic [N_DEV*VEC_W-1:0] DEV_VEC =
        {9'o220, 9'o200, 9'o104, 9'o100, 9'o074, 9'o070, 9'o064, 9'o060},
    parameter logic [N_TRAP*VEC_W-1:0] TRAP_VEC =
        {9'o250, 9'o244, 9'o240, 9'o114, 9'o034, 9'o030,
         9'o024, 9'o020, 9'o014, 9'o010, 9'o004}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DEV-1:0]  dev_req,
    input  logic [N_TRAP-1:0] trap_req,
    input  logic [LVL_W-1:0]  cpu_pri,
    input  logic              ack,
    output logic              take,
    output logic [VEC_W-1:0]  vector,
    output logic [N_DEV-1:0]  dev_clr
);
    import virq_pkg::*;

    localparam int unsigned N_MAX = (N_DEV > N_TRAP) ? N_DEV : N_TRAP;
    localparam int unsigned SRC_W = (N_MAX > 1) ? $clog2(N_MAX) : 1;

    typedef struct packed {
        arb_state_e       st;
        logic             take;
        logic [VEC_W-1:0] vec;
        logic             is_trap;
        logic [SRC_W-1:0] src;
        logic [N_DEV-1:0] clr;
    } arb_regs_t;

    arb_regs_t r_q, r_d;

    logic             dev_found, trap_found;
    logic [SRC_W-1:0] dev_idx, trap_idx;
    logic [VEC_W-1:0] dev_vec, trap_vec;

    virq_dev_select #(
        .N_DEV  (N_DEV),
        .LVL_W  (LVL_W),
        .VEC_W  (VEC_W),
        .SRC_W  (SRC_W),
        .DEV_LVL(DEV_LVL),
        .DEV_VEC(DEV_VEC)
    ) u_dev (
        .req    (dev_req),
        .cpu_pri(cpu_pri),
        .found  (dev_found),
        .idx    (dev_idx),
        .vec    (dev_vec)
    );

    virq_trap_select #(
        .N_TRAP  (N_TRAP),
        .VEC_W   (VEC_W),
        .SRC_W   (SRC_W),
        .TRAP_VEC(TRAP_VEC)
    ) u_trap (
        .req  (trap_req),
        .found(trap_found),
        .idx  (trap_idx),
        .vec  (trap_vec)
    );

    always_comb begin
        r_d     = r_q;
        r_d.clr = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (trap_found) begin
                    r_d.st      = ST_HOLD;
                    r_d.take    = 1'b1;
                    r_d.vec     = trap_vec;
                    r_d.is_trap = 1'b1;
                    r_d.src     = trap_idx;
                end else if (dev_found) begin
                    r_d.st      = ST_HOLD;
                    r_d.take    = 1'b1;
                    r_d.vec     = dev_vec;
                    r_d.is_trap = 1'b0;
                    r_d.src     = dev_idx;
                end
            end
            ST_HOLD: begin
                if (ack) begin
                    r_d.st   = ST_CLEAR;
                    r_d.take = 1'b0;
                    r_d.vec  = '0;
                    for (int i = 0; i < N_DEV; i++) begin
                        r_d.clr[i] = !r_q.is_trap && (r_q.src == SRC_W'(i));
                    end
                end
            end
            ST_CLEAR: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.take = 1'b0;
                r_d.vec  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, take: 1'b0, vec: '0, is_trap: 1'b0,
                     src: '0, clr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign take    = r_q.take;
    assign vector  = r_q.vec;
    assign dev_clr = r_q.clr;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        take && !ack |=> take && $stable(vector)); // R7
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        take && ack |=> !take); // R8
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_clr)); // R8
    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_clr) |=> (dev_clr == '0) && !take); // R8
    AST_CLR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_clr) |-> $past(take && ack)); // R8
    AST_TRAP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) && (|trap_req) |=> take && r_q.is_trap); // R4
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> vector == '0); // R9

endmodule

// File: tb/tb_vec_irq_arbiter.sv
module tb_vec_irq_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dev_req = '0;
    logic [10:0] trap_req = '0;
    logic [2:0]  cpu_pri = '0;
    logic        ack = 1'b0;
    logic        take;
    logic [8:0]  vector;
    logic [7:0]  dev_clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vec_irq_arbiter dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .trap_req(trap_req),
        .cpu_pri(cpu_pri), .ack(ack), .take(take), .vector(vector),
        .dev_clr(dev_clr)
    );

    // Tables written from the requirement text (R6)
    function automatic int dlvl(int i);
        case (i)
            4, 5: return 6;
            7:    return 5;
            default: return 4;
        endcase
    endfunction

    function automatic logic [8:0] dvec(int i);
        case (i)
            0: return 9'o060; 1: return 9'o064; 2: return 9'o070; 3: return 9'o074;
            4: return 9'o100; 5: return 9'o104; 6: return 9'o200; default: return 9'o220;
        endcase
    endfunction

    function automatic logic [8:0] tvec(int i);
        case (i)
            0: return 9'o004; 1: return 9'o010; 2: return 9'o014; 3: return 9'o020;
            4: return 9'o024; 5: return 9'o030; 6: return 9'o034; 7: return 9'o114;
            8: return 9'o240; 9: return 9'o244; default: return 9'o250;
        endcase
    endfunction

    // Reference model state
    int         m_st = 0;   // 0 free, 1 presenting, 2 clear cycle
    bit         m_take = 0;
    logic [8:0] m_vec = '0;
    bit         m_trap = 0;
    int         m_src = 0;
    logic [7:0] m_clr = '0;

    task automatic model_edge();
        int st_n = m_st; bit tk = m_take; logic [8:0] v = m_vec;
        bit tr = m_trap; int s = m_src; logic [7:0] c = '0;
        if (m_st == 0) begin
            int best = -1;
            for (int i = 10; i >= 0; i--) if (trap_req[i]) best = i;
            if (best >= 0) begin
                st_n = 1; tk = 1; v = tvec(best); tr = 1; s = best;
            end else begin
                for (int i = 0; i < 8; i++)
                    if (dev_req[i] && dlvl(i) > int'(cpu_pri) &&
                        (best < 0 || dlvl(i) > dlvl(best))) best = i;
                if (best >= 0) begin
                    st_n = 1; tk = 1; v = dvec(best); tr = 0; s = best;
                end
            end
        end else if (m_st == 1) begin
            if (ack) begin
                st_n = 2; tk = 0; v = '0;
                if (!m_trap) c[m_src] = 1'b1;
            end
        end else begin
            st_n = 0;
        end
        m_st = st_n; m_take = tk; m_vec = v; m_trap = tr; m_src = s; m_clr = c;
    endtask

    task automatic check(string tag);
        checks++;
        if (take !== m_take || vector !== m_vec || dev_clr !== m_clr) begin
            errors++;
            $display("FAIL %s: take=%0b vector=%o dev_clr=%b expected take=%0b vector=%o dev_clr=%b",
                     tag, take, vector, dev_clr, m_take, m_vec, m_clr);
        end
    endtask

    // Inputs already set (after a falling edge); cross one rising edge and check
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        #1;
        check(tag);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        dev_req = '0; trap_req = '0; ack = 1'b0;
    endtask

    // Present a request, check it, acknowledge, run through the clear cycle
    task automatic present_ack(logic [7:0] d, logic [10:0] t, logic [2:0] p, string tag);
        dev_req = d; trap_req = t; cpu_pri = p; ack = 1'b0;
        step(tag);
        ack = 1'b1;
        step(tag);
        idle_inputs();
        step(tag);
        step(tag);
    endtask

    initial begin
        repeat (5000000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        #1; checks++;
        if (take !== 1'b0 || vector !== '0 || dev_clr !== '0) begin
            errors++;
            $display("FAIL R1: take=%0b vector=%o dev_clr=%b expected 0 0 0", take, vector, dev_clr);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1 first cycle after reset");

        // R2: level-4 device masked at 4, shown at 3
        dev_req = 8'b0000_0001; cpu_pri = 3'd4;
        step("R2 masked at equal level");
        step("R2 masked at equal level");
        cpu_pri = 3'd7;
        step("R2 masked above level");
        cpu_pri = 3'd3;
        step("R2 shown below level");
        ack = 1'b1;
        step("R8 ack with clear pulse");
        idle_inputs();
        step("R8 clear lasts one cycle");

        // R3: highest level wins, tie to lowest index
        present_ack(8'b1001_0001, '0, 3'd0, "R3 highest level");
        present_ack(8'b0011_0000, '0, 3'd0, "R3 tie lowest index");
        present_ack(8'b1100_1111, '0, 3'd4, "R3 level 5 over masked level 4");

        // R4: trap beats devices at top priority
        present_ack(8'b0011_0000, 11'b000_0100_0000, 3'd7, "R4 trap over devices");
        // R5: simultaneous traps
        present_ack('0, 11'b100_0000_0001, 3'd0, "R5 bus timeout first");
        present_ack('0, 11'b110_1000_0000, 3'd0, "R5 ascending order");

        // R7: held winner ignores new inputs and stale ack is ignored while free
        ack = 1'b1;
        step("R7 ack ignored while free");
        ack = 1'b0; dev_req = 8'b0000_0100; cpu_pri = 3'd0;
        step("R9 device presented next edge");
        trap_req = 11'b000_0000_0001; dev_req = 8'b0011_0000; cpu_pri = 3'd7;
        step("R7 held against trap");
        step("R7 held against trap");
        ack = 1'b1;
        step("R8 ack drops take");
        ack = 1'b0;
        step("R8 trap waits out clear cycle");
        step("R4 trap presented after clear");
        ack = 1'b1; trap_req = '0;
        step("R8 trap ack without clear");
        idle_inputs();
        step("R8 trap ack without clear");

        // R6 and R10 sweeps
        for (int i = 0; i < 11; i++) present_ack('0, 11'(1) << i, 3'd0, "R6 trap vector");
        for (int i = 0; i < 8; i++) present_ack(8'(1) << i, '0, 3'd3, "R10 device at priority 3");
        for (int i = 0; i < 8; i++) present_ack(8'(1) << i, '0, 3'd0, "R6 device vector");

        // Seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            dev_req = 8'($urandom);
            trap_req = (($urandom % 8) == 0) ? (11'(1) << ($urandom % 11)) : '0;
            if (($urandom % 16) == 0) trap_req = 11'($urandom);
            cpu_pri = 3'($urandom);
            ack = (($urandom % 3) == 0);
            step("R2 R3 R4 R7 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule